// File: doc/BRIEF.md
# Wired Interrupt Aggregator

This block gathers a set of interrupt source lines (32 by default) into one pending-cause register and drives a single wired interrupt line towards a parent interrupt controller. Software reaches it through a plain 32-bit register port with an address, a write strobe with data, and a read strobe with data. Through that port it masks sources, reads which causes are pending, clears them, forces them pending again to retrigger a source, and picks one capture mode, level or rising edge, for every source of the instance at once.

Each source has its own capture cell. In level mode a high input sets its pending bit on every cycle. In rising-edge mode only a low-to-high transition sets it, and the bit then holds until software clears it. A pending bit that its mask bit does not block asserts the wired output, which comes from a flop. The register port has no back-pressure: a write takes effect at the clock edge where the strobe is high, and read data is combinational and valid in the cycle the read strobe is high. A message-signalled path is not built. Its disable bit can only be stored and read back.

Top module: `wire_irq_agg`

## Requirements
- R1: After reset the pending register is 0, every implemented mask bit is 1, both configuration bits are 0 and `irq_o` is 0.
- R2: Reads use byte offsets: 0x00 returns pending, 0x10 returns mask, and 0x28 returns the rising-mode bit at bit 3 and the message-disable bit at bit 5. The force offset 0x08 reads as 0. Data bits at and above `N_SRC`, and every other configuration bit, read as 0. `rd_data_o` is 0 whenever `rd_en_i` is low.
- R3: A write to offset 0x00 clears each pending bit whose data bit is 0 and keeps each bit whose data bit is 1. The new value is visible one clock after the write.
- R4: A write to offset 0x08 makes pending every bit whose data bit is 1. Data bits that are 0 have no effect.
- R5: `irq_o` equals the OR over all sources of (pending AND NOT mask), one clock after the pending and mask values it reflects. A mask bit of 1 blocks its source.
- R6: With configuration bit 3 set, a 0-to-1 transition on a source between two clock edges sets its pending bit. A source held high does not set it again after a clear, and a falling edge sets nothing.
- R7: With configuration bit 3 clear, a source that is high sets its pending bit at every edge. A clear written while the source is still high leaves the bit set.
- R8: When a capture event and a software clear hit the same bit at the same edge, the bit ends up set. This holds in both modes.
- R9: Configuration bit 5 is stored and read back but changes neither capture nor `irq_o`.
- R10: Writes to unmapped offsets change no register, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Interrupt source lines, synchronous to clk_i |
| addr_i | input | ADDR_W | Byte offset of the register access |
| wr_en_i | input | 1 | Write strobe, one access per cycle |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | DATA_W | Read data, combinational, zero when not reading |
| irq_o | output | 1 | Registered wired interrupt to the parent controller |

## Verification
The bench builds the block with `N_SRC = 8`, `DATA_W = 32` and `ADDR_W = 6`. Eight sources make every one of the 256 source, pending and force patterns reachable. Each pattern runs through level capture, edge capture, clear-by-zero and three mask choices. The 32-bit data width with only eight sources also shows that the unused upper bits of pending and mask read as zero.

// File: rtl/wia_pkg.sv
package wia_pkg;

  // Byte offsets of the software-visible registers
  localparam int OFF_PEND  = 'h00;
  localparam int OFF_FORCE = 'h08;
  localparam int OFF_MASK  = 'h10;
  localparam int OFF_CFG   = 'h28;

  // Configuration register bit positions
  localparam int CFG_RISE_BIT   = 3;
  localparam int CFG_MSGOFF_BIT = 5;

  typedef struct packed {
    logic rise_mode;   // 1: rising-edge capture, 0: level capture
    logic msg_off;     // message path disabled (stored only)
  } cfg_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_FORCE,
    SEL_MASK,
    SEL_CFG
  } reg_sel_e;

endpackage

// File: rtl/wia_regs.sv
module wia_regs
  import wia_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [N_SRC-1:0]  pend_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [N_SRC-1:0]  mask_o,
  output cfg_t              cfg_o,
  output logic [N_SRC-1:0]  clr_o,
  output logic [N_SRC-1:0]  force_o
);

  reg_sel_e         sel;
  logic [N_SRC-1:0] mask_q;
  cfg_t             cfg_q;

  // Address decode
  always_comb begin
    if (addr_i == ADDR_W'(OFF_PEND))       sel = SEL_PEND;
    else if (addr_i == ADDR_W'(OFF_FORCE)) sel = SEL_FORCE;
    else if (addr_i == ADDR_W'(OFF_MASK))  sel = SEL_MASK;
    else if (addr_i == ADDR_W'(OFF_CFG))   sel = SEL_CFG;
    else                                   sel = SEL_NONE;
  end

  // Stored registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      cfg_q  <= '0;
    end else if (wr_en_i) begin
      if (sel == SEL_MASK) mask_q <= wr_data_i[N_SRC-1:0];
      if (sel == SEL_CFG) begin
        cfg_q.rise_mode <= wr_data_i[CFG_RISE_BIT];
        cfg_q.msg_off   <= wr_data_i[CFG_MSGOFF_BIT];
      end
    end
  end

  // Per-bit strobes towards the capture cells
  always_comb begin
    clr_o   = '0;
    force_o = '0;
    if (wr_en_i && sel == SEL_PEND)  clr_o   = ~wr_data_i[N_SRC-1:0];
    if (wr_en_i && sel == SEL_FORCE) force_o = wr_data_i[N_SRC-1:0];
  end

  // Read mux
  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      case (sel)
        SEL_PEND: rd_data_o[N_SRC-1:0] = pend_i;
        SEL_MASK: rd_data_o[N_SRC-1:0] = mask_q;
        SEL_CFG: begin
          rd_data_o[CFG_RISE_BIT]   = cfg_q.rise_mode;
          rd_data_o[CFG_MSGOFF_BIT] = cfg_q.msg_off;
        end
        default: rd_data_o = '0;
      endcase
    end
  end

  assign mask_o = mask_q;
  assign cfg_o  = cfg_q;

endmodule

// File: rtl/wia_cell.sv
module wia_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic rise_mode_i,
  input  logic clr_i,
  input  logic force_i,
  output logic pend_o
);

  logic prev_q;
  logic hw_set;

  // Capture event: the level itself, or a low-to-high step
  always_comb hw_set = rise_mode_i ? (src_i & ~prev_q) : src_i;

  // Set sources override the software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      prev_q <= src_i;
      pend_o <= hw_set | force_i | (pend_o & ~clr_i);
    end
  end

endmodule

// File: rtl/wia_combine.sv
module wia_combine #(
  parameter int N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] mask_i,
  output logic             irq_o
);

  logic any_live;

  always_comb any_live = |(pend_i & ~mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= any_live;
  end

endmodule

// File: rtl/wire_irq_agg.sv
module wire_irq_agg
  import wia_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);

  logic [N_SRC-1:0] pend_w;
  logic [N_SRC-1:0] mask_w;
  logic [N_SRC-1:0] clr_w;
  logic [N_SRC-1:0] force_w;
  cfg_t             cfg_w;

  wia_regs #(
    .N_SRC (N_SRC),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .rd_en_i  (rd_en_i),
    .pend_i   (pend_w),
    .rd_data_o(rd_data_o),
    .mask_o   (mask_w),
    .cfg_o    (cfg_w),
    .clr_o    (clr_w),
    .force_o  (force_w)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_cell
    wia_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (src_i[i]),
      .rise_mode_i(cfg_w.rise_mode),
      .clr_i      (clr_w[i]),
      .force_i    (force_w[i]),
      .pend_o     (pend_w[i])
    );
  end

  wia_combine #(
    .N_SRC(N_SRC)
  ) u_combine (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pend_i(pend_w),
    .mask_i(mask_w),
    .irq_o (irq_o)
  );

endmodule

// File: rtl/wia_chk.sv
module wia_chk
  import wia_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  src_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              irq_o,
  input logic [N_SRC-1:0]  pend,
  input logic [N_SRC-1:0]  mask,
  input logic              rise_mode
);

  logic             armed;
  logic [N_SRC-1:0] src_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed <= 1'b0;
      src_d <= '0;
    end else begin
      armed <= 1'b1;
      src_d <= src_i;
    end
  end

  // R5: output only follows an unmasked pending bit
  a_r5_irq_needs_cause: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    irq_o |-> $past(|(pend & ~mask)));

  // R5: an unmasked pending bit raises the output on the next edge
  a_r5_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend & ~mask)) |=> irq_o);

  // R7: level mode captures every high source
  a_r7_level_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_mode |=> ((pend & $past(src_i)) == $past(src_i)));

  // R4: forced bits are pending after the write
  a_r4_force_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(OFF_FORCE)) |=>
      ((pend & $past(wr_data_i[N_SRC-1:0])) == $past(wr_data_i[N_SRC-1:0])));

  // R6: in edge mode a new pending bit needs a rising edge
  a_r6_edge_only: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (rise_mode && !(wr_en_i && addr_i == ADDR_W'(OFF_FORCE))) |=>
      ((pend & ~$past(pend) & ~($past(src_i) & ~$past(src_d))) == '0));

  // R10: mask changes only through its own offset
  a_r10_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_W'(OFF_MASK)) |=> $stable(mask));

endmodule

bind wire_irq_agg wia_chk #(
  .N_SRC (N_SRC),
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .src_i    (src_i),
  .addr_i   (addr_i),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .irq_o    (irq_o),
  .pend     (pend_w),
  .mask     (mask_w),
  .rise_mode(cfg_w.rise_mode)
);

// File: tb/tb_wire_irq_agg.sv
`timescale 1ns/1ps
module tb_wire_irq_agg;

  localparam int NS = 8;
  localparam int DW = 32;
  localparam int AW = 6;

  localparam logic [AW-1:0] A_PEND  = 6'h00;
  localparam logic [AW-1:0] A_FORCE = 6'h08;
  localparam logic [AW-1:0] A_MASK  = 6'h10;
  localparam logic [AW-1:0] A_CFG   = 6'h28;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  wire_irq_agg #(.N_SRC(NS), .DATA_W(DW), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr),
    .wr_en_i(wr_en), .wr_data_i(wdata), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(A_PEND, v);  check("R1 pend", v, 32'h0);
    rd(A_MASK, v);  check("R1 mask", v, 32'hFF);
    rd(A_CFG, v);   check("R1 cfg", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2: read map details
    rd(A_FORCE, v); check("R2 force reads 0", v, 32'h0);
    addr = A_MASK; rd_en = 1'b0; #1;
    check("R2 no read strobe", rd_data, 32'h0);
    wr(A_CFG, 32'hFFFF_FFFF);
    rd(A_CFG, v);   check("R2 cfg bits", v, 32'h28);
    wr(A_MASK, 32'hFFFF_FF0F);
    rd(A_MASK, v);  check("R2 mask width", v, 32'h0F);

    // R10: unmapped offsets
    wr(6'h18, 32'h0);
    wr(6'h30, 32'h0);
    rd(A_MASK, v);  check("R10 mask kept", v, 32'h0F);
    rd(A_CFG, v);   check("R10 cfg kept", v, 32'h28);
    rd(6'h04, v);   check("R10 unmapped read", v, 32'h0);
    wr(A_CFG, 32'h0);
    wr(A_FORCE, 32'h3C);
    wr(6'h0C, 32'h0);
    rd(A_PEND, v);  check("R10 pend kept", v, 32'h3C);
    rd(6'h3C, v);   check("R10 unmapped read2", v, 32'h0);

    // R3: clear by writing zero, sweep
    for (int i = 0; i < 256; i++) begin
      logic [7:0] s, w;
      s = 8'(i); w = 8'(i * 37 + 11);
      wr(A_PEND, 32'h0);
      wr(A_FORCE, {24'h0, s});
      wr(A_PEND, {24'hFF_FFFF, w});
      rd(A_PEND, v);
      check("R3 clear-by-zero", v, {24'h0, s & w});
    end

    // R4 and R5: force patterns against three masks
    for (int i = 0; i < 256; i++) begin
      for (int k = 0; k < 3; k++) begin
        logic [7:0] p, m;
        p = 8'(i);
        m = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (p ^ 8'h5A);
        wr(A_MASK, {24'h0, m});
        wr(A_PEND, 32'h0);
        wr(A_FORCE, {24'hFFFF_FF, p} & 32'h0000_00FF);
        rd(A_PEND, v);
        check("R4 force", v, {24'h0, p});
        tick();
        check("R5 irq", {31'b0, irq}, {31'b0, |(p & ~m)});
      end
    end

    // R7 and R8: level capture sweep
    wr(A_CFG, 32'h0);
    wr(A_MASK, 32'hFF);
    wr(A_PEND, 32'h0);
    for (int i = 0; i < 256; i++) begin
      logic [7:0] p;
      p = 8'(i);
      src = p;
      tick();
      rd(A_PEND, v);  check("R7 level capture", v, {24'h0, p});
      wr(A_PEND, 32'h0);
      rd(A_PEND, v);  check("R8 level clear loses", v, {24'h0, p});
      src = '0;
      wr(A_PEND, 32'h0);
      rd(A_PEND, v);  check("R7 level cleared", v, 32'h0);
    end

    // R6: rising-edge capture sweep
    wr(A_CFG, 32'h08);
    for (int i = 0; i < 256; i++) begin
      logic [7:0] p;
      p = 8'(i);
      src = p;
      tick();
      rd(A_PEND, v);  check("R6 edge capture", v, {24'h0, p});
      wr(A_PEND, 32'h0);
      rd(A_PEND, v);  check("R6 edge cleared", v, 32'h0);
      tick();
      rd(A_PEND, v);  check("R6 held high no reset", v, 32'h0);
      src = '0;
      tick();
      rd(A_PEND, v);  check("R6 falling ignored", v, 32'h0);
    end

    // R8: edge event and clear at the same edge
    src = 8'h10;
    wr(A_PEND, 32'h0);
    rd(A_PEND, v);  check("R8 edge set wins", v, 32'h10);
    src = '0;
    wr(A_PEND, 32'h0);

    // R9: message-disable bit has no effect
    wr(A_CFG, 32'h28);
    rd(A_CFG, v);   check("R9 cfg readback", v, 32'h28);
    wr(A_MASK, 32'h0);
    src = 8'h81;
    tick();
    rd(A_PEND, v);  check("R9 edge capture", v, 32'h81);
    tick();
    check("R9 irq", {31'b0, irq}, 32'h1);
    src = '0;
    wr(A_CFG, 32'h20);
    wr(A_PEND, 32'h0);
    tick();
    check("R9 irq low", {31'b0, irq}, 32'h0);
    src = 8'h02;
    tick();
    rd(A_PEND, v);  check("R9 level capture", v, 32'h02);
    tick();
    check("R9 irq level", {31'b0, irq}, 32'h1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule